// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This controller gathers ninety-six level-sensitive interrupt sources into three banks of thirty-two: a primary-low bank (ids 0-31), a primary-high bank (ids 32-63) and a pin bank (ids 64-95). The pin bank latches its inputs into a sticky cause register. Its enabled pending bits are folded, eight at a time, into four summary bits that sit at positions 24-27 of the primary-high cause. This is the cascade. A single CPU interrupt line is raised whenever either primary bank has an enabled pending bit.

Software reaches the block through a plain 32-bit register port with two windows, primary and pin, chosen by a window-select input. To service an interrupt, software reads either a select-cause word or a ready-made vector word. The select-cause word returns whichever primary half holds enabled work, and bit 30 of that word tells which half it is. The vector word carries the bank in bits 6:5 and the highest pending source of that bank in bits 4:0. When the primary-high work comes only from the summary bits, the vector resolves further into the pin bank.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset the CPU mask-low and pin mask read 0, CPU mask-high reads 0x0F000000 (summary bits 24-27 enabled), the pin cause reads 0, cpu_irq is 0 and the vector reads 0x80000000.
- R2: Primary cause-low (offset 0x04) and the bits of primary cause-high (offset 0x0C) outside 24-27 read the corresponding input lines as sampled at the previous clock edge.
- R3: Pin cause (pin window, offset 0x08) bit i becomes 1 at any clock edge where gpp_pin[i] is high. A write there clears each bit whose data bit is 0 and keeps each bit whose data bit is 1. A pin that is high in the same cycle as a clearing write leaves its bit set.
- R4: CPU mask-low (0x14), CPU mask-high (0x1C) and the pin mask (pin window, 0x0C) are read/write, take effect from the edge of the write, and a mask bit of 1 enables its source.
- R5: cpu_irq is 1 exactly when (cause-low AND mask-low) or (cause-high AND mask-high) is non-zero.
- R6: Cause-high bit 24+k (k = 0..3) is the OR of the enabled pin cause bits 8k through 8k+7.
- R7: Select-cause (0x24) returns cause-low with bit 30 cleared when enabled low work exists. Otherwise, when enabled high work exists, it returns cause-high with bit 30 set. Otherwise it returns cause-low with bit 30 cleared.
- R8: Vector (0x28) returns {bank, index}, with bank in bits 6:5 (0 low, 1 high, 2 pin) and index in bits 4:0. Index is the highest set bit of that bank's enabled cause. Low has priority. High resolves to the pin bank when any enabled summary bit 24-27 is set. The word is 0x80000000 when nothing is pending.
- R9: Writes to cause-low, cause-high, select-cause and vector change nothing. Reads of unmapped offsets in either window return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_low | input | 32 | Level source lines, ids 0-31 |
| src_high | input | 32 | Level source lines, ids 32-63 (bits 24-27 unused) |
| gpp_pin | input | 32 | Pin bank source lines, ids 64-95 |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_gpp_sel | input | 1 | 1 selects the pin window, 0 the primary window |
| bus_addr | input | 8 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current window and offset |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
An acknowledge write to the pin cause and a fresh assertion of the same pin can land on one clock edge. In that case the latch must win and the bit must survive. The bench forces this collision directly by writing the inverse of one bit while holding that pin high, and it also produces it at random by mixing clearing writes with sparse pin activity. A mask write can likewise coincide with a source change. After every edge, cause, select-cause, vector and cpu_irq are compared against a model built from the requirements.

// File: rtl/casc_irq_pkg.sv
`timescale 1ns/1ps
package casc_irq_pkg;

    localparam int GRP_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int IDX_W    = $clog2(GRP_W);
    localparam int SUM_BASE = 24;
    localparam int SUM_CNT  = 4;
    localparam int SEL_FLAG = 30;

    // primary window
    localparam logic [ADDR_W-1:0] OFF_CAUSE_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CAUSE_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_SELECT   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_VECTOR   = 8'h28;
    // pin window
    localparam logic [ADDR_W-1:0] OFF_PIN_CAUSE = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_PIN_MASK  = 8'h0C;

    typedef enum logic [1:0] {
        BANK_LOW  = 2'd0,
        BANK_HIGH = 2'd1,
        BANK_PIN  = 2'd2
    } bank_e;

    typedef struct packed {
        logic [GRP_W-1:0] cause;
        logic [GRP_W-1:0] mask;
    } pin_state_t;

    typedef struct packed {
        logic [GRP_W-1:0] lo;
        logic [GRP_W-1:0] hi;
        logic [GRP_W-1:0] mlo;
        logic [GRP_W-1:0] mhi;
    } main_state_t;

    // index of the most significant set bit (0 when none)
    function automatic logic [IDX_W-1:0] top_index(input logic [GRP_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < GRP_W; i++) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_bank.sv
`timescale 1ns/1ps
module irq_pin_bank
    import casc_irq_pkg::*;
#(
    parameter int W   = GRP_W,
    parameter int NSUM = SUM_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    pin,
    input  logic            wr_cause,
    input  logic            wr_mask,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    cause,
    output logic [W-1:0]    mask,
    output logic [W-1:0]    masked,
    output logic [NSUM-1:0] summary
);
    localparam int SPAN = W / NSUM;

    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cause) st_d.cause = st_q.cause & wdata;
        st_d.cause = st_d.cause | pin;          // latch wins over clear
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause  = st_q.cause;
    assign mask   = st_q.mask;
    assign masked = st_q.cause & st_q.mask;

    for (genvar k = 0; k < NSUM; k++) begin : g_sum
        assign summary[k] = |masked[k*SPAN +: SPAN];
    end

endmodule

// File: rtl/irq_main_bank.sv
`timescale 1ns/1ps
module irq_main_bank
    import casc_irq_pkg::*;
#(
    parameter int W     = GRP_W,
    parameter int SBASE = SUM_BASE,
    parameter int NSUM  = SUM_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    src_lo,
    input  logic [W-1:0]    src_hi,
    input  logic [NSUM-1:0] pin_sum,
    input  logic            wr_mlo,
    input  logic            wr_mhi,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    cause_lo,
    output logic [W-1:0]    cause_hi,
    output logic [W-1:0]    mask_lo,
    output logic [W-1:0]    mask_hi,
    output logic [W-1:0]    pend_lo,
    output logic [W-1:0]    pend_hi,
    output logic            irq
);
    localparam logic [W-1:0] SUM_FIELD = W'(((1 << NSUM) - 1) << SBASE);

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic [W-1:0] mlo;
        logic [W-1:0] mhi;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] sum_vec;

    always_comb begin
        st_d    = st_q;
        st_d.lo = src_lo;
        st_d.hi = src_hi & ~SUM_FIELD;
        if (wr_mlo) st_d.mlo = wdata;
        if (wr_mhi) st_d.mhi = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mhi <= SUM_FIELD;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_vec  = W'({{(W-NSUM){1'b0}}, pin_sum}) << SBASE;
    assign cause_lo = st_q.lo;
    assign cause_hi = st_q.hi | sum_vec;
    assign mask_lo  = st_q.mlo;
    assign mask_hi  = st_q.mhi;
    assign pend_lo  = cause_lo & st_q.mlo;
    assign pend_hi  = cause_hi & st_q.mhi;
    assign irq      = (|pend_lo) | (|pend_hi);

endmodule

// File: rtl/irq_vector_enc.sv
`timescale 1ns/1ps
module irq_vector_enc
    import casc_irq_pkg::*;
#(
    parameter int W     = GRP_W,
    parameter int SBASE = SUM_BASE,
    parameter int NSUM  = SUM_CNT,
    parameter int FLAG  = SEL_FLAG
) (
    input  logic [W-1:0] cause_lo,
    input  logic [W-1:0] cause_hi,
    input  logic [W-1:0] pend_lo,
    input  logic [W-1:0] pend_hi,
    input  logic [W-1:0] pend_pin,
    output logic [W-1:0] select,
    output logic [W-1:0] vector
);
    localparam int IW = $clog2(W);
    localparam logic [W-1:0] SUM_FIELD = W'(((1 << NSUM) - 1) << SBASE);

    always_comb begin
        select = cause_lo;
        select[FLAG] = 1'b0;
        vector = '0;
        if (|pend_lo) begin
            vector[IW +: 2]  = 2'(BANK_LOW);
            vector[IW-1:0]   = top_index(pend_lo);
        end else if (|pend_hi) begin
            select = cause_hi;
            select[FLAG] = 1'b1;
            if (|(pend_hi & SUM_FIELD)) begin
                vector[IW +: 2] = 2'(BANK_PIN);
                vector[IW-1:0]  = top_index(pend_pin);
            end else begin
                vector[IW +: 2] = 2'(BANK_HIGH);
                vector[IW-1:0]  = top_index(pend_hi);
            end
        end else begin
            vector[W-1] = 1'b1;
        end
    end

endmodule

// File: rtl/casc_irq_ctrl.sv
`timescale 1ns/1ps
module casc_irq_ctrl
    import casc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  src_low,
    input  logic [GRP_W-1:0]  src_high,
    input  logic [GRP_W-1:0]  gpp_pin,
    input  logic              bus_wr,
    input  logic              bus_gpp_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GRP_W-1:0]  bus_wdata,
    output logic [GRP_W-1:0]  bus_rdata,
    output logic              cpu_irq
);
    logic wr_main, wr_pin;
    logic [GRP_W-1:0] pin_cause_w, pin_mask_w, pin_masked_w;
    logic [SUM_CNT-1:0] pin_sum_w;
    logic [GRP_W-1:0] cause_lo_w, cause_hi_w, mask_lo_w, mask_hi_w;
    logic [GRP_W-1:0] pend_lo_w, pend_hi_w, select_w, vector_w;

    assign wr_main = bus_wr & ~bus_gpp_sel;
    assign wr_pin  = bus_wr &  bus_gpp_sel;

    irq_pin_bank #(.W(GRP_W), .NSUM(SUM_CNT)) pin_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (gpp_pin),
        .wr_cause (wr_pin && bus_addr == OFF_PIN_CAUSE),
        .wr_mask  (wr_pin && bus_addr == OFF_PIN_MASK),
        .wdata    (bus_wdata),
        .cause    (pin_cause_w),
        .mask     (pin_mask_w),
        .masked   (pin_masked_w),
        .summary  (pin_sum_w)
    );

    irq_main_bank #(.W(GRP_W), .SBASE(SUM_BASE), .NSUM(SUM_CNT)) main_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lo   (src_low),
        .src_hi   (src_high),
        .pin_sum  (pin_sum_w),
        .wr_mlo   (wr_main && bus_addr == OFF_MASK_LO),
        .wr_mhi   (wr_main && bus_addr == OFF_MASK_HI),
        .wdata    (bus_wdata),
        .cause_lo (cause_lo_w),
        .cause_hi (cause_hi_w),
        .mask_lo  (mask_lo_w),
        .mask_hi  (mask_hi_w),
        .pend_lo  (pend_lo_w),
        .pend_hi  (pend_hi_w),
        .irq      (cpu_irq)
    );

    irq_vector_enc #(.W(GRP_W), .SBASE(SUM_BASE), .NSUM(SUM_CNT), .FLAG(SEL_FLAG)) enc_i (
        .cause_lo (cause_lo_w),
        .cause_hi (cause_hi_w),
        .pend_lo  (pend_lo_w),
        .pend_hi  (pend_hi_w),
        .pend_pin (pin_masked_w),
        .select   (select_w),
        .vector   (vector_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_gpp_sel) begin
            case (bus_addr)
                OFF_PIN_CAUSE: bus_rdata = pin_cause_w;
                OFF_PIN_MASK:  bus_rdata = pin_mask_w;
                default:       bus_rdata = '0;
            endcase
        end else begin
            case (bus_addr)
                OFF_CAUSE_LO: bus_rdata = cause_lo_w;
                OFF_CAUSE_HI: bus_rdata = cause_hi_w;
                OFF_MASK_LO:  bus_rdata = mask_lo_w;
                OFF_MASK_HI:  bus_rdata = mask_hi_w;
                OFF_SELECT:   bus_rdata = select_w;
                OFF_VECTOR:   bus_rdata = vector_w;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/casc_irq_chk.sv
`timescale 1ns/1ps
module casc_irq_chk
    import casc_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [GRP_W-1:0] src_low,
    input logic [GRP_W-1:0] gpp_pin,
    input logic             bus_wr,
    input logic             cpu_irq,
    input logic [GRP_W-1:0] cause_lo,
    input logic [GRP_W-1:0] cause_hi,
    input logic [GRP_W-1:0] mask_lo,
    input logic [GRP_W-1:0] mask_hi,
    input logic [GRP_W-1:0] pin_cause,
    input logic [GRP_W-1:0] pin_masked,
    input logic [GRP_W-1:0] vector
);
    AST_LOW_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cause_lo == $past(src_low)); // R2

    AST_PIN_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin_cause & $past(gpp_pin)) == $past(gpp_pin)); // R3

    AST_PIN_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin_cause & ~$past(pin_cause) & ~$past(gpp_pin)) == '0); // R3

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr)) |-> (mask_lo == $past(mask_lo) && mask_hi == $past(mask_hi))); // R4

    AST_IRQ_AGREES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == !vector[GRP_W-1]); // R5

    AST_SUMMARY_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_hi[SUM_BASE +: SUM_CNT] != '0) == (pin_masked != '0)); // R6

    AST_VECTOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        !vector[GRP_W-1] |-> (vector[GRP_W-2:IDX_W+2] == '0 && vector[IDX_W +: 2] != 2'd3)); // R8
endmodule

bind casc_irq_ctrl casc_irq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_low    (src_low),
    .gpp_pin    (gpp_pin),
    .bus_wr     (bus_wr),
    .cpu_irq    (cpu_irq),
    .cause_lo   (cause_lo_w),
    .cause_hi   (cause_hi_w),
    .mask_lo    (mask_lo_w),
    .mask_hi    (mask_hi_w),
    .pin_cause  (pin_cause_w),
    .pin_masked (pin_masked_w),
    .vector     (vector_w)
);

// File: tb/casc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module casc_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_low = '0, src_high = '0, gpp_pin = '0;
    logic        bus_wr = 1'b0, bus_gpp_sel = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state, from the requirements
    logic [31:0] m_lo, m_hi, m_mlo, m_mhi, m_pc, m_pm;

    always #2 clk = ~clk;

    casc_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_low(src_low), .src_high(src_high),
        .gpp_pin(gpp_pin), .bus_wr(bus_wr), .bus_gpp_sel(bus_gpp_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq)
    );

    function automatic logic [4:0] msb(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
        return r;
    endfunction

    function automatic logic [31:0] exp_hi();
        logic [31:0] h = m_hi & ~32'h0F00_0000;
        logic [31:0] pm = m_pc & m_pm;
        for (int k = 0; k < 4; k++) h[24+k] = |pm[8*k +: 8];
        return h;
    endfunction

    function automatic logic [31:0] exp_select();
        logic [31:0] r;
        if (|(m_lo & m_mlo))              begin r = m_lo; r[30] = 1'b0; end
        else if (|(exp_hi() & m_mhi))     begin r = exp_hi(); r[30] = 1'b1; end
        else                              begin r = m_lo; r[30] = 1'b0; end
        return r;
    endfunction

    function automatic logic [31:0] exp_vector();
        logic [31:0] pl = m_lo & m_mlo;
        logic [31:0] ph = exp_hi() & m_mhi;
        if (|pl) return {27'd0, msb(pl)};
        if (|ph) begin
            if (|ph[27:24]) return 32'd64 | {27'd0, msb(m_pc & m_pm)};
            return 32'd32 | {27'd0, msb(ph)};
        end
        return 32'h8000_0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic g, input logic [7:0] a, output logic [31:0] d);
        bus_gpp_sel = g;
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic check_all();
        logic [31:0] d;
        rd(1'b0, 8'h04, d); chk("R2 cause-low", d, m_lo);
        rd(1'b0, 8'h0C, d); chk("R6 cause-high", d, exp_hi());
        rd(1'b0, 8'h24, d); chk("R7 select-cause", d, exp_select());
        rd(1'b0, 8'h28, d); chk("R8 vector", d, exp_vector());
        rd(1'b1, 8'h08, d); chk("R3 pin cause", d, m_pc);
        rd(1'b0, 8'h14, d); chk("R4 mask-low", d, m_mlo);
        rd(1'b0, 8'h1C, d); chk("R4 mask-high", d, m_mhi);
        rd(1'b1, 8'h0C, d); chk("R4 pin mask", d, m_pm);
        chk("R5 cpu_irq", {31'd0, cpu_irq},
            {31'd0, (|(m_lo & m_mlo)) | (|(exp_hi() & m_mhi))});
    endtask

    // drive at a falling edge, model the rising edge, return at next falling edge
    task automatic step(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] pin,
                        input logic wr, input logic g, input logic [7:0] a, input logic [31:0] d);
        src_low = lo; src_high = hi; gpp_pin = pin;
        bus_wr = wr; bus_gpp_sel = g; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_lo = lo;
        m_hi = hi;
        if (wr && g && a == 8'h08) m_pc = m_pc & d;
        m_pc = m_pc | pin;
        if (wr && g && a == 8'h0C) m_pm = d;
        if (wr && !g && a == 8'h14) m_mlo = d;
        if (wr && !g && a == 8'h1C) m_mhi = d;
        @(negedge clk);
        bus_wr = 1'b0;
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0] addrs [8];
        void'($urandom(32'h5EED_1234));
        addrs = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h28, 8'h30};
        m_lo = '0; m_hi = '0; m_mlo = '0; m_mhi = 32'h0F00_0000; m_pc = '0; m_pm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, 8'h1C, d); chk("R1 mask-high reset", d, 32'h0F00_0000);
        rd(1'b0, 8'h14, d); chk("R1 mask-low reset", d, 32'h0);
        rd(1'b1, 8'h0C, d); chk("R1 pin mask reset", d, 32'h0);
        rd(1'b1, 8'h08, d); chk("R1 pin cause reset", d, 32'h0);
        rd(1'b0, 8'h28, d); chk("R1 vector idle", d, 32'h8000_0000);
        chk("R1 cpu_irq reset", {31'd0, cpu_irq}, 32'd0);

        // R2/R7/R8 low bank, highest enabled bit wins
        step(32'h0000_0110, 32'h0, 32'h0, 1'b1, 1'b0, 8'h14, 32'h0000_0130);
        step(32'h0000_0110, 32'h0, 32'h0, 1'b0, 1'b0, 8'h00, 32'h0);
        rd(1'b0, 8'h28, d); chk("R8 low vector id 8", d, 32'd8);
        // R9 write to cause-low ignored
        step(32'h0000_0110, 32'h0, 32'h0, 1'b1, 1'b0, 8'h04, 32'h0);
        rd(1'b0, 8'h04, d); chk("R9 cause-low unchanged by write", d, 32'h0000_0110);
        step(32'h0000_0110, 32'h0, 32'h0, 1'b1, 1'b0, 8'h28, 32'h0);
        rd(1'b0, 8'h28, d); chk("R9 vector unchanged by write", d, 32'd8);
        rd(1'b0, 8'h30, d); chk("R9 unmapped primary reads 0", d, 32'h0);
        rd(1'b1, 8'h10, d); chk("R9 unmapped pin reads 0", d, 32'h0);

        // R7/R8 high bank when low idle
        step(32'h0, 32'h4000_0008, 32'h0, 1'b1, 1'b0, 8'h1C, 32'h4F00_0008);
        step(32'h0, 32'h4000_0008, 32'h0, 1'b0, 1'b0, 8'h00, 32'h0);
        rd(1'b0, 8'h28, d); chk("R8 high vector id 62", d, 32'd62);
        rd(1'b0, 8'h24, d); chk("R7 select flag high", d, 32'h4000_0008);

        // R3/R6/R8 pin bank, pin 17 -> summary bit 26 -> id 81
        step(32'h0, 32'h0, 32'h0002_0000, 1'b1, 1'b1, 8'h0C, 32'h0002_0000);
        step(32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 8'h1C, 32'h0F00_0000);
        rd(1'b0, 8'h0C, d); chk("R6 summary bit 26", d, 32'h0400_0000);
        rd(1'b0, 8'h28, d); chk("R8 pin vector id 81", d, 32'd81);
        // R3 ack colliding with the same pin high: bit survives
        step(32'h0, 32'h0, 32'h0002_0000, 1'b1, 1'b1, 8'h08, ~32'h0002_0000);
        rd(1'b1, 8'h08, d); chk("R3 latch beats clear", d, 32'h0002_0000);
        // R3 writing ones keeps the bit
        step(32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF);
        rd(1'b1, 8'h08, d); chk("R3 write-1 keeps", d, 32'h0002_0000);
        // R3 ack with pin low clears
        step(32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 8'h08, ~32'h0002_0000);
        rd(1'b1, 8'h08, d); chk("R3 write-0 clears", d, 32'h0);
        chk("R5 irq drops after ack", {31'd0, cpu_irq}, 32'd0);

        // random traffic, model checked every cycle
        for (int n = 0; n < 600; n++) begin
            logic [31:0] lo, hi, pin, wd;
            logic wr, g;
            logic [7:0] a;
            lo  = $urandom & $urandom & $urandom;
            hi  = $urandom & $urandom & $urandom;
            pin = $urandom & $urandom & $urandom & $urandom;
            wr  = ($urandom % 3) == 0;
            g   = $urandom % 2;
            a   = addrs[$urandom % 8];
            wd  = ($urandom % 2) ? ~(32'd1 << ($urandom % 32)) : ($urandom & $urandom);
            step(lo, hi, pin, wr, g, a, wd);
        end
        finish_run();
    end

endmodule